// File: doc/BRIEF.md
# UART Interrupt Identification Prioritizer

This block is the interrupt controller of a 16550-style UART. Neighbouring logic (receive and transmit FIFOs, the serializer, the line and modem status registers) reports raw events and levels to it. It keeps the pending state of five interrupt sources, masks them with its own interrupt enable register, picks the most urgent enabled source, encodes it as the interrupt identification byte, and drives an active-low interrupt line. The modem control "OUT2" bit gates that line.

Each source has its own way of clearing. Line status clears on a status register read and modem status on a modem status read. Data available follows the receive FIFO fill level against the trigger threshold. Character timeout clears on a receive data read. Transmit-holding-empty (THRE) clears on a transmit data write, or on an identification read that actually reported THRE. In FIFO mode the THRE event is held back until the serializer marks the end of the last character, unless the transmit FIFO held two or more bytes since it last ran dry. The identification byte the CPU sees is a registered snapshot that stays frozen while the read strobe is high.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, iir_rdata reads 0x01, irq_n is 1 and ier_rdata reads 0x00.
- R2: An ier_we write stores ier_wdata[3:0]. ier_rdata[7:4] always read 0.
- R3: The reported source follows a fixed priority order. Line status is highest and gives code 0110 in bits 3:0. Data available (0100) is next, then character timeout (1100) at the same level but below data available, then THRE (0010), then modem status (0000). With nothing enabled and pending, bits 3:0 read 0001.
- R4: IER bit 0 enables data available and timeout, bit 1 enables THRE, bit 2 enables line status and bit 3 enables modem status. A disabled source is never reported.
- R5: irq_n is 0 exactly when out2 is 1 and at least one enabled source is pending.
- R6: iir_rdata[7:6] read 11 when fifo_en is 1 and 00 otherwise. iir_rdata[5:4] read 0.
- R7: A lsr_evt pulse sets line status pending until a lsr_rd pulse. A msr_evt pulse sets modem status pending until a msr_rd pulse.
- R8: Data available is pending while rx_cnt is at or above the trigger level in FIFO mode. The rx_trig codes 0, 1, 2 and 3 select levels 1, 4, 8 and 14. Outside FIFO mode, data available is pending while rx_cnt is nonzero.
- R9: A rx_tmo_evt pulse sets timeout pending until a rhr_rd pulse.
- R10: A thr_wr pulse clears THRE pending. An iir_rd pulse clears it only when iir_rdata[3:0] is 0010 in that cycle.
- R11: When tx_cnt falls to 0, THRE becomes pending at once in two cases: outside FIFO mode, or when tx_cnt reached 2 or more since it last was 0. Otherwise THRE waits for a tx_char_mark pulse.
- R12: A fcr_wr pulse while tx_cnt is 0 makes THRE pending on the next cycle.
- R13: iir_rdata follows the internal state one cycle late and holds its value in every cycle while iir_rd stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_we | input | 1 | Interrupt enable register write strobe |
| ier_wdata | input | 8 | Interrupt enable write data |
| ier_rdata | output | 8 | Interrupt enable read value |
| fifo_en | input | 1 | FIFO mode level |
| fcr_wr | input | 1 | FIFO control write pulse |
| rx_trig | input | 2 | Receive trigger level code |
| out2 | input | 1 | Interrupt output enable (modem control OUT2) |
| lsr_evt | input | 1 | Receive line error event pulse |
| lsr_rd | input | 1 | Line status read pulse |
| msr_evt | input | 1 | Modem input change event pulse |
| msr_rd | input | 1 | Modem status read pulse |
| rx_cnt | input | CNT_W | Receive FIFO fill level |
| rx_tmo_evt | input | 1 | Character timeout event pulse |
| rhr_rd | input | 1 | Receive data read pulse |
| thr_wr | input | 1 | Transmit data write pulse |
| tx_cnt | input | CNT_W | Transmit FIFO fill level |
| tx_char_mark | input | 1 | Serializer pulse at end of last character before its final stop bit |
| iir_rd | input | 1 | Identification register read strobe |
| iir_rdata | output | 8 | Identification register read value |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that read and write pulses come from a register decoder, so the bench drives them away from the sampling edge and holds each one for single cycles. The one exception is iir_rd, which the freeze property allows to stay high for several cycles. They also assume that rx_cnt and tx_cnt never exceed the FIFO depth. The bench keeps both counts within 0 to 16 and clears all sources with read and write pulses before it builds each new set of pending sources. It drives tx_cnt on its own, separately from thr_wr. It does this only in the THRE-delay tests, and in those tests a thr_wr always comes before the count sequence so that no stale THRE state is carried in.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef struct packed {
    logic ls;
    logic rda;
    logic tmo;
    logic thre;
    logic ms;
  } irq_src_t;

  localparam logic [3:0] CODE_LS   = 4'b0110;
  localparam logic [3:0] CODE_RDA  = 4'b0100;
  localparam logic [3:0] CODE_TMO  = 4'b1100;
  localparam logic [3:0] CODE_THRE = 4'b0010;
  localparam logic [3:0] CODE_MS   = 4'b0000;
  localparam logic [3:0] CODE_NONE = 4'b0001;

  // Receive threshold selected by the two-bit trigger code.
  function automatic int unsigned rx_trig_level(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  // Apply enable bits: [0] rx data/timeout, [1] thre, [2] line, [3] modem.
  function automatic irq_src_t mask_src(input irq_src_t raw, input logic [3:0] en);
    irq_src_t m;
    m.ls   = raw.ls   & en[2];
    m.rda  = raw.rda  & en[0];
    m.tmo  = raw.tmo  & en[0];
    m.thre = raw.thre & en[1];
    m.ms   = raw.ms   & en[3];
    return m;
  endfunction

endpackage

// File: rtl/uart_irq_thre.sv
module uart_irq_thre #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             fcr_wr,
  input  logic             thr_wr,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic             tx_char_mark,
  input  logic             iir_rd,
  input  logic             thre_shown,
  output logic             thre_pend
);

  logic tx_empty, empty_q, empty_rise;
  logic multi_q, hold_q, pend_q;

  assign tx_empty   = (tx_cnt == '0);
  assign empty_rise = tx_empty & ~empty_q;
  assign thre_pend  = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      multi_q <= 1'b0;
    end else begin
      empty_q <= tx_empty;
      if (empty_rise || fcr_wr)            multi_q <= 1'b0;
      else if (tx_cnt >= CNT_W'(2))        multi_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hold_q <= 1'b0;
    end else if (thr_wr) begin
      pend_q <= 1'b0;
      hold_q <= 1'b0;
    end else if (fcr_wr && tx_empty) begin
      pend_q <= 1'b1;
      hold_q <= 1'b0;
    end else if (empty_rise) begin
      if (fifo_en && !multi_q) hold_q <= 1'b1;
      else                     pend_q <= 1'b1;
    end else if (hold_q && tx_char_mark) begin
      pend_q <= 1'b1;
      hold_q <= 1'b0;
    end else if (iir_rd && thre_shown) begin
      pend_q <= 1'b0;
    end
  end

  AST_THR_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !thre_pend); // R10

  AST_FCR_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_wr && tx_empty && !thr_wr) |=> thre_pend); // R12

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  irq_src_t   src,
  output logic [4:0] grant,
  output logic [3:0] code,
  output logic       any
);

  always_comb begin
    grant = '0;
    code  = CODE_NONE;
    if (src.ls) begin
      grant[4] = 1'b1; code = CODE_LS;
    end else if (src.rda) begin
      grant[3] = 1'b1; code = CODE_RDA;
    end else if (src.tmo) begin
      grant[2] = 1'b1; code = CODE_TMO;
    end else if (src.thre) begin
      grant[1] = 1'b1; code = CODE_THRE;
    end else if (src.ms) begin
      grant[0] = 1'b1; code = CODE_MS;
    end
  end

  assign any = |grant;

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_we,
  input  logic [7:0]       ier_wdata,
  output logic [7:0]       ier_rdata,
  input  logic             fifo_en,
  input  logic             fcr_wr,
  input  logic [1:0]       rx_trig,
  input  logic             out2,
  input  logic             lsr_evt,
  input  logic             lsr_rd,
  input  logic             msr_evt,
  input  logic             msr_rd,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic             rx_tmo_evt,
  input  logic             rhr_rd,
  input  logic             thr_wr,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic             tx_char_mark,
  input  logic             iir_rd,
  output logic [7:0]       iir_rdata,
  output logic             irq_n
);

  logic [3:0] ier_q;
  logic       ls_q, ms_q, tmo_q;
  logic       rda_lvl, thre_pend, thre_shown, any_pend;
  logic [7:0] iir_q, iir_now;
  logic [4:0] grant;
  logic [3:0] code;
  irq_src_t   raw_src, en_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ier_q <= '0;
    else if (ier_we) ier_q <= ier_wdata[3:0];
  end
  assign ier_rdata = {4'b0000, ier_q};

  // Sticky sources: a new event wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls_q  <= 1'b0;
      ms_q  <= 1'b0;
      tmo_q <= 1'b0;
    end else begin
      if (lsr_evt)         ls_q  <= 1'b1;
      else if (lsr_rd)     ls_q  <= 1'b0;
      if (msr_evt)         ms_q  <= 1'b1;
      else if (msr_rd)     ms_q  <= 1'b0;
      if (rx_tmo_evt)      tmo_q <= 1'b1;
      else if (rhr_rd)     tmo_q <= 1'b0;
    end
  end

  assign rda_lvl = fifo_en ? (32'(rx_cnt) >= rx_trig_level(rx_trig))
                           : (rx_cnt != '0);

  assign thre_shown = (iir_q[3:0] == CODE_THRE);

  uart_irq_thre #(.CNT_W(CNT_W)) u_thre (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .fcr_wr(fcr_wr),
    .thr_wr(thr_wr), .tx_cnt(tx_cnt), .tx_char_mark(tx_char_mark),
    .iir_rd(iir_rd), .thre_shown(thre_shown), .thre_pend(thre_pend)
  );

  always_comb begin
    raw_src.ls   = ls_q;
    raw_src.rda  = rda_lvl;
    raw_src.tmo  = tmo_q;
    raw_src.thre = thre_pend;
    raw_src.ms   = ms_q;
  end
  assign en_src = mask_src(raw_src, ier_q);

  uart_irq_prio u_prio (.src(en_src), .grant(grant), .code(code), .any(any_pend));

  assign iir_now = {{2{fifo_en}}, 2'b00, code};

  // Snapshot seen by the CPU; frozen for the whole read strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) iir_q <= 8'h01;
    else if (!iir_rd) iir_q <= iir_now;
  end
  assign iir_rdata = iir_q;

  assign irq_n = ~(out2 & any_pend);

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R3

  AST_OUT2_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !out2 |-> irq_n); // R5

  AST_LS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_q && !lsr_rd) |=> ls_q); // R7

  AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rhr_rd && !rx_tmo_evt) |=> !tmo_q); // R9

  AST_IIR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    iir_rd |=> $stable(iir_rdata)); // R13

endmodule

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ier_we = 0, fifo_en = 0, fcr_wr = 0, out2 = 0;
  logic lsr_evt = 0, lsr_rd = 0, msr_evt = 0, msr_rd = 0;
  logic rx_tmo_evt = 0, rhr_rd = 0, thr_wr = 0, tx_char_mark = 0, iir_rd = 0;
  logic [7:0] ier_wdata = 0, ier_rdata, iir_rdata;
  logic [1:0] rx_trig = 2'd3;
  logic [CW-1:0] rx_cnt = 0, tx_cnt = 0;
  logic irq_n;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ctrl u0 (.*);

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_iir(input logic [4:0] s, input logic [3:0] en, input logic fe);
    logic [3:0] lo;
    if (s[0] && en[2])      lo = 4'h6;
    else if (s[1] && en[0]) lo = 4'h4;
    else if (s[2] && en[0]) lo = 4'hC;
    else if (s[3] && en[1]) lo = 4'h2;
    else if (s[4] && en[3]) lo = 4'h0;
    else                    lo = 4'h1;
    return {fe, fe, 2'b00, lo};
  endfunction

  task automatic clear_all();
    lsr_rd = 1; msr_rd = 1; rhr_rd = 1; thr_wr = 1; rx_cnt = 0;
    step();
    lsr_rd = 0; msr_rd = 0; rhr_rd = 0; thr_wr = 0;
  endtask

  task automatic set_ier(input logic [7:0] v);
    ier_we = 1; ier_wdata = v; step(); ier_we = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1", iir_rdata, 8'h01);
    chk("R1", {7'd0, irq_n}, 8'h01);
    chk("R1", ier_rdata, 8'h00);
    rst_n = 1;
    step();
    // R2 upper enable bits read zero
    set_ier(8'hFF);
    chk("R2", ier_rdata, 8'h0F);
    set_ier(8'hA5);
    chk("R2", ier_rdata, 8'h05);

    // R3 R4 R5 R6 sweep: all source subsets x all enable masks
    for (int s = 0; s < 32; s++) begin
      logic [4:0] sv;
      sv = 5'(s);
      clear_all();
      fifo_en = sv[2] ^ sv[4];
      lsr_evt = sv[0]; rx_cnt = sv[1] ? CW'(16) : CW'(0);
      rx_tmo_evt = sv[2]; fcr_wr = sv[3]; msr_evt = sv[4];
      step();
      lsr_evt = 0; rx_tmo_evt = 0; fcr_wr = 0; msr_evt = 0;
      for (int e = 0; e < 16; e++) begin
        logic [7:0] ex;
        out2 = 1;
        set_ier(8'(e));
        step();
        ex = exp_iir(sv, 4'(e), fifo_en);
        chk("R3/R4/R6 iir", iir_rdata, ex);
        chk("R5 irq", {7'd0, irq_n}, {7'd0, ex[3:0] == 4'h1});
        out2 = 0; #1;
        chk("R5 out2 gate", {7'd0, irq_n}, 8'h01);
      end
    end

    // R8 trigger thresholds
    clear_all(); out2 = 1; set_ier(8'h01); fifo_en = 1;
    for (int c = 0; c < 4; c++) begin
      int lvl;
      lvl = (c == 3) ? 14 : ((c == 0) ? 1 : (4 << (c - 1)));
      rx_trig = 2'(c);
      for (int n = 0; n <= 16; n++) begin
        rx_cnt = CW'(n); #1;
        chk("R8 fifo level", {7'd0, irq_n}, {7'd0, !(n >= lvl)});
      end
    end
    fifo_en = 0;
    for (int n = 0; n < 3; n++) begin
      rx_cnt = CW'(n); #1;
      chk("R8 non-fifo", {7'd0, irq_n}, {7'd0, n == 0});
    end
    rx_cnt = 0; rx_trig = 2'd3;

    // R9 timeout set and cleared by a data read
    fifo_en = 1; clear_all();
    rx_tmo_evt = 1; step(); rx_tmo_evt = 0; step();
    chk("R9 set", iir_rdata, 8'hCC);
    rhr_rd = 1; step(); rhr_rd = 0; step();
    chk("R9 clear", iir_rdata, 8'hC1);

    // R7 line status and modem status
    set_ier(8'h0C);
    lsr_evt = 1; step(); lsr_evt = 0; step(); step();
    chk("R7 ls hold", iir_rdata, 8'hC6);
    lsr_rd = 1; step(); lsr_rd = 0; step();
    chk("R7 ls clear", iir_rdata, 8'hC1);
    msr_evt = 1; step(); msr_evt = 0; step();
    chk("R7 ms set", iir_rdata, 8'hC0);
    msr_rd = 1; step(); msr_rd = 0; step();
    chk("R7 ms clear", iir_rdata, 8'hC1);

    // R12 and R10: THRE from FCR write, cleared by identification read
    set_ier(8'h02);
    fcr_wr = 1; step(); fcr_wr = 0; step();
    chk("R12 fcr thre", iir_rdata, 8'hC2);
    iir_rd = 1; step(); iir_rd = 0; step();
    chk("R10 iir read clears", iir_rdata, 8'hC1);
    set_ier(8'h06);
    fcr_wr = 1; lsr_evt = 1; step(); fcr_wr = 0; lsr_evt = 0; step();
    chk("R10 ls shown", iir_rdata, 8'hC6);
    iir_rd = 1; step(); iir_rd = 0;
    lsr_rd = 1; step(); lsr_rd = 0; step();
    chk("R10 thre kept", iir_rdata, 8'hC2);
    thr_wr = 1; step(); thr_wr = 0; step();
    chk("R10 thr write clears", iir_rdata, 8'hC1);

    // R11 delayed THRE in FIFO mode
    set_ier(8'h02);
    tx_cnt = 1; step(); tx_cnt = 0; step(); step();
    chk("R11 held", iir_rdata, 8'hC1);
    tx_char_mark = 1; step(); tx_char_mark = 0; step();
    chk("R11 after mark", iir_rdata, 8'hC2);
    thr_wr = 1; step(); thr_wr = 0;
    tx_cnt = 1; step(); tx_cnt = 2; step(); tx_cnt = 1; step(); tx_cnt = 0;
    step(); step();
    chk("R11 two bytes immediate", iir_rdata, 8'hC2);
    thr_wr = 1; step(); thr_wr = 0; fifo_en = 0;
    tx_cnt = 1; step(); tx_cnt = 0; step(); step();
    chk("R11 non-fifo immediate", iir_rdata, 8'h02);

    // R13 snapshot frozen during a long read
    fifo_en = 1; thr_wr = 1; step(); thr_wr = 0;
    set_ier(8'h05); step();
    chk("R13 before", iir_rdata, 8'hC1);
    iir_rd = 1; lsr_evt = 1; step(); lsr_evt = 0;
    chk("R13 frozen 1", iir_rdata, 8'hC1);
    step();
    chk("R13 frozen 2", iir_rdata, 8'hC1);
    iir_rd = 0; step();
    chk("R13 released", iir_rdata, 8'hC6);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule